// File: doc/BRIEF.md
# Flash Read Front End with Mode-Dependent Address Capture

This block sits on the device side of a partitioned NOR-style flash with a 16-bit data bus. It receives the bus control strobes (chip enable, output enable, write enable, reset, address valid), the bus clock and the word address. From these it builds the address that the storage array sees, decodes which partition that address falls in, and drives the array word onto the data bus only when a read is permitted.

Two read modes exist. After reset the block reads asynchronously: while address-valid is low the address flows straight through, and when address-valid rises the last address seen is held. A configuration write selects the synchronous burst mode. In that mode a clock edge with address-valid low loads the address, and each later clock edge with address-valid high and the chip selected steps to the next word. Each partition holds 8 Mbit (512K words), so the partition index is the word-address field above bit 18. The storage array is a computed stand-in: each word equals the low 16 address bits XORed with the address bits above bit 15.

Top module: `flrd_front`

## Requirements
- R1: While reset is low the data drive enable is low. After reset the mode is asynchronous and the held address is zero, so with address-valid high the bus shows the word at address 0.
- R2: A rising clock edge with chip enable low and write enable low loads the mode when the data input, with bit 15 masked, equals 0x0060: bit 15 = 0 selects synchronous burst mode, bit 15 = 1 selects asynchronous mode.
- R3: A write cycle whose data word, with bit 15 masked, differs from 0x0060 leaves the mode unchanged.
- R4: In asynchronous mode with address-valid low, the bus word follows the address input in the same cycle, with no clock edge.
- R5: In asynchronous mode, after address-valid rises, the bus word is that of the address present at the last rising clock edge that had address-valid low, chip enable low and write enable high.
- R6: In synchronous mode, a rising clock edge with address-valid low, chip enable low and write enable high loads the address; the address input has no effect on the bus before that edge.
- R7: In synchronous mode, each rising clock edge with address-valid high, chip enable low and write enable high advances the word address by one, wrapping from all ones to zero.
- R8: A rising clock edge with chip enable high neither loads nor advances the address.
- R9: The partition index output is word-address bits 23:19 of the current array address, and the partition select output is one-hot with bit set at that index.
- R10: The data drive enable is high only when reset, write enable are high and chip enable, output enable are low; when it is low the data output is zero.
- R11: The word presented equals address bits 15:0 XOR the zero-extended address bits 23:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| adv_n | input | 1 | Active-low address valid |
| addr_i | input | 24 | Word address |
| dq_i | input | 16 | Data bus input for configuration writes |
| dq_o | output | 16 | Data bus output value |
| dq_oe | output | 1 | Data bus drive enable (low means high-impedance) |
| part_idx_o | output | 5 | Index of the partition being addressed |
| part_sel_o | output | 32 | One-hot partition select |

## Verification
The bus word, drive enable and partition outputs are combinational from the current array address and the strobes, so they are due in the same cycle as a strobe change or, in asynchronous flow-through, an address change. The mode bit, the held address and the burst step change only at a rising clock edge and are due from that edge onward. The bench moves all inputs just after a falling edge and samples 5 ns later, still before the next rising edge, so each check sees either the pure combinational response or the state from exactly one earlier edge. Sweeps cover every partition, a burst across the top-of-space wrap, and mode switching in both directions.

// File: rtl/flrd_pkg.sv
package flrd_pkg;
   typedef enum logic {
      RD_ASYNC = 1'b0,
      RD_SYNC  = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/flrd_mode_reg.sv
module flrd_mode_reg
   import flrd_pkg::*;
#(
   parameter int          DQ_W     = 16,
   parameter int          MODE_BIT = 15,
   parameter logic [15:0] CFG_WORD = 16'h0060
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ce_n,
   input  logic            we_n,
   input  logic [DQ_W-1:0] dq_i,
   output rd_mode_e        mode_o
);
   localparam logic [DQ_W-1:0] MODE_MASK = DQ_W'(1) << MODE_BIT;
   localparam logic [DQ_W-1:0] KEY       = DQ_W'(CFG_WORD) & ~MODE_MASK;

   rd_mode_e mode_q;
   logic     wr_cyc;
   logic     key_hit;

   assign wr_cyc  = !ce_n && !we_n;
   assign key_hit = (dq_i & ~MODE_MASK) == KEY;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= RD_ASYNC;
      end else if (wr_cyc && key_hit) begin
         mode_q <= dq_i[MODE_BIT] ? RD_ASYNC : RD_SYNC;
      end
   end

   assign mode_o = mode_q;

   // R3: a write with a foreign data word leaves the mode alone
   p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cyc && !key_hit) |=> $stable(mode_q));
   // R2: mode only moves after a keyed write
   p_mode_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_q) |-> $past(wr_cyc && key_hit));
endmodule

// File: rtl/flrd_addr_latch.sv
module flrd_addr_latch
   import flrd_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rd_mode_e          mode_i,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              adv_n,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] eff_addr_o
);
   logic [ADDR_W-1:0] latch_q;
   logic              bus_rd_side;
   logic              load_en;
   logic              step_en;

   assign bus_rd_side = !ce_n && we_n;
   assign load_en     = bus_rd_side && !adv_n;
   assign step_en     = bus_rd_side && adv_n && (mode_i == RD_SYNC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (load_en) begin
         latch_q <= addr_i;
      end else if (step_en) begin
         latch_q <= latch_q + ADDR_W'(1);
      end
   end

   always_comb begin
      if (mode_i == RD_ASYNC && !adv_n) begin
         eff_addr_o = addr_i;
      end else begin
         eff_addr_o = latch_q;
      end
   end

   // R7: burst step by one word, wrapping
   p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> latch_q == ADDR_W'($past(latch_q) + ADDR_W'(1)));
   // R8: deselected chip holds the address
   p_ce_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> $stable(latch_q));
   // R5: async tracking while address-valid is low
   p_async_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == RD_ASYNC && load_en) |=> latch_q == $past(addr_i));
endmodule

// File: rtl/flrd_part_decode.sv
module flrd_part_decode #(
   parameter int PART_W = 5,
   localparam int NUM_PART = 1 << PART_W
) (
   input  logic [PART_W-1:0]   upper_i,
   output logic [PART_W-1:0]   idx_o,
   output logic [NUM_PART-1:0] sel_o
);
   assign idx_o = upper_i;

   for (genvar p = 0; p < NUM_PART; p++) begin : g_sel
      assign sel_o[p] = (upper_i == PART_W'(p));
   end
endmodule

// File: rtl/flrd_array_model.sv
module flrd_array_model #(
   parameter int ADDR_W = 24,
   parameter int DQ_W   = 16
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [DQ_W-1:0]   data_o
);
   if (ADDR_W > DQ_W) begin : g_fold
      localparam int HI_W = ADDR_W - DQ_W;
      logic [HI_W-1:0] hi;
      assign hi     = addr_i[ADDR_W-1:DQ_W];
      assign data_o = addr_i[DQ_W-1:0] ^ DQ_W'(hi);
   end else begin : g_plain
      assign data_o = DQ_W'(addr_i);
   end
endmodule

// File: rtl/flrd_out_gate.sv
module flrd_out_gate #(
   parameter int DQ_W = 16
) (
   input  logic            rst_n,
   input  logic            ce_n,
   input  logic            oe_n,
   input  logic            we_n,
   input  logic [DQ_W-1:0] data_i,
   output logic [DQ_W-1:0] dq_o,
   output logic            dq_oe
);
   logic rd_ok;

   assign rd_ok = rst_n && we_n && !ce_n && !oe_n;
   assign dq_oe = rd_ok;
   assign dq_o  = rd_ok ? data_i : '0;
endmodule

// File: rtl/flrd_front.sv
module flrd_front
   import flrd_pkg::*;
#(
   parameter int          ADDR_W   = 24,
   parameter int          DQ_W     = 16,
   parameter int          PART_LSB = 19,
   parameter int          MODE_BIT = 15,
   parameter logic [15:0] CFG_WORD = 16'h0060,
   localparam int         PART_W   = ADDR_W - PART_LSB,
   localparam int         NUM_PART = 1 << PART_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce_n,
   input  logic                oe_n,
   input  logic                we_n,
   input  logic                adv_n,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DQ_W-1:0]     dq_i,
   output logic [DQ_W-1:0]     dq_o,
   output logic                dq_oe,
   output logic [PART_W-1:0]   part_idx_o,
   output logic [NUM_PART-1:0] part_sel_o
);
   if (PART_LSB < 1 || PART_LSB >= ADDR_W) begin : g_bad_part
      $error("flrd_front: PART_LSB must lie inside the address");
   end
   if (PART_W > 8) begin : g_bad_count
      $error("flrd_front: too many partitions for the select vector");
   end
   if (MODE_BIT < 0 || MODE_BIT >= DQ_W || DQ_W > 16) begin : g_bad_dq
      $error("flrd_front: mode bit or data width out of range");
   end

   rd_mode_e          mode;
   logic [ADDR_W-1:0] eff_addr;
   logic [DQ_W-1:0]   arr_data;

   flrd_mode_reg #(
      .DQ_W(DQ_W), .MODE_BIT(MODE_BIT), .CFG_WORD(CFG_WORD)
   ) u_mode (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
      .dq_i(dq_i), .mode_o(mode)
   );

   flrd_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .ce_n(ce_n), .we_n(we_n),
      .adv_n(adv_n), .addr_i(addr_i), .eff_addr_o(eff_addr)
   );

   flrd_part_decode #(.PART_W(PART_W)) u_part (
      .upper_i(eff_addr[ADDR_W-1:PART_LSB]),
      .idx_o(part_idx_o), .sel_o(part_sel_o)
   );

   flrd_array_model #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_array (
      .addr_i(eff_addr), .data_o(arr_data)
   );

   flrd_out_gate #(.DQ_W(DQ_W)) u_gate (
      .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .data_i(arr_data), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   // R10: output enable high never drives the bus
   p_oe_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n || ce_n || !we_n) |-> !dq_oe);
   // R9: exactly one partition selected
   p_part_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(part_sel_o));
   // R9: select and index agree
   p_part_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      part_sel_o[part_idx_o]);
endmodule

// File: tb/sim_flrd_front.sv
module sim_flrd_front;
   logic        clk = 1'b0;
   logic        rst_n, ce_n, oe_n, we_n, adv_n;
   logic [23:0] addr_i;
   logic [15:0] dq_i;
   logic [15:0] dq_o;
   logic        dq_oe;
   logic [4:0]  part_idx_o;
   logic [31:0] part_sel_o;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   flrd_front u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .adv_n(adv_n), .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o),
      .dq_oe(dq_oe), .part_idx_o(part_idx_o), .part_sel_o(part_sel_o)
   );

   function automatic logic [15:0] word_of(input logic [23:0] a);
      return a[15:0] ^ {8'h00, a[23:16]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_word(input string tag, input logic [23:0] a);
      chk(tag, {15'd0, dq_oe, dq_o}, {15'd0, 1'b1, word_of(a)});
      chk({tag, " partition"}, {27'd0, part_idx_o}, {27'd0, a[23:19]});
      chk({tag, " select"}, part_sel_o, 32'd1 << a[23:19]);
   endtask

   task automatic cfg_write(input logic [15:0] w);
      @(negedge clk);
      we_n = 1'b0; adv_n = 1'b1; dq_i = w;
      @(negedge clk);
      we_n = 1'b1; dq_i = 16'h0000;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      logic [23:0] a_hold, a_burst;
      rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; adv_n = 1'b1;
      addr_i = 24'h123456; dq_i = 16'h0000;
      repeat (3) @(negedge clk);
      #5 chk("R1 reset drive", {31'd0, dq_oe}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #5 chk_word("R1 reset address", 24'h000000);

      // R4 / R9 / R11: flow-through sweep over every partition
      for (int p = 0; p < 32; p++) begin
         @(negedge clk);
         adv_n = 1'b0;
         addr_i = {p[4:0], 19'h0ABCD ^ 19'(p * 777)};
         #5 chk_word("R4 R9 R11 flow", addr_i);
         addr_i = addr_i ^ 24'h00F0F0;
         #1 chk_word("R4 flow no edge", addr_i);
      end

      // R5: hold on address-valid rise
      @(negedge clk);
      adv_n = 1'b0; addr_i = 24'h2A5A5A; a_hold = 24'h2A5A5A;
      @(negedge clk);
      adv_n = 1'b1; addr_i = 24'hF00F00;
      #5 chk_word("R5 async hold", a_hold);

      // R10: drive gating
      oe_n = 1'b1;
      #1 chk("R10 oe high", {15'd0, dq_oe, dq_o}, 32'd0);
      oe_n = 1'b0; ce_n = 1'b1;
      #1 chk("R10 ce high", {15'd0, dq_oe, dq_o}, 32'd0);
      ce_n = 1'b0; we_n = 1'b0;
      #1 chk("R10 we low", {15'd0, dq_oe, dq_o}, 32'd0);
      we_n = 1'b1;

      // R3: foreign word must not change the mode
      cfg_write(16'h0061);
      cfg_write(16'h4060);
      adv_n = 1'b0; addr_i = 24'h3C3C3C;
      #5 chk_word("R3 still async", 24'h3C3C3C);

      // R2 / R6: enter synchronous mode
      @(negedge clk);
      adv_n = 1'b1;
      cfg_write(16'h0060);
      adv_n = 1'b0; addr_i = 24'h456789; a_burst = 24'h456789;
      #5 chk_word("R2 R6 no flow before edge", 24'h3C3C3C);
      @(negedge clk);
      adv_n = 1'b1; addr_i = 24'h000000;
      #5 chk_word("R6 sync load", a_burst);

      // R7: burst steps
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         #5 chk_word("R7 burst step", a_burst + 24'(k));
      end

      // R8: deselected chip holds
      @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b0;
      #5 chk_word("R8 ce hold", a_burst + 24'd7);

      // R7 / R9: wrap across the top of the address space
      @(negedge clk);
      adv_n = 1'b0; addr_i = 24'hFFFFFE;
      @(negedge clk);
      adv_n = 1'b1;
      #5 chk_word("R7 wrap start", 24'hFFFFFE);
      @(negedge clk);
      #5 chk_word("R7 wrap top", 24'hFFFFFF);
      @(negedge clk);
      #5 chk_word("R7 R9 wrap zero", 24'h000000);

      // R2: back to asynchronous mode
      cfg_write(16'h8060);
      adv_n = 1'b0; addr_i = 24'h0F1E2D;
      #5 chk_word("R2 back to async", 24'h0F1E2D);

      // R1: reset returns the mode to async and clears the address
      @(negedge clk);
      adv_n = 1'b1;
      cfg_write(16'h0060);
      rst_n = 1'b0;
      #2 chk("R1 reset drive again", {31'd0, dq_oe}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1; adv_n = 1'b1;
      #5 chk_word("R1 address cleared", 24'h000000);
      adv_n = 1'b0; addr_i = 24'h5E5E5E;
      #1 chk_word("R1 mode default async", 24'h5E5E5E);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule